// File: doc/BRIEF.md
# Layered Function-Element Array

This block is a small reconfigurable fabric whose whole behaviour is set by a 383-bit configuration word. The word is meant to be produced by an evolutionary search, so every one of its 2^383 values must describe a legal circuit. No value can create a loop, a floating node or two drivers on one net.

The fabric has five layers, and each layer feeds only the one after it. The first layer has sixteen routing elements. Each of them gathers any three of the 32 input bits into a 3-bit group. The four later layers hold 6, 4, 2 and 1 function elements. Each function element picks two groups from the layer before it and combines them with one of eight operations, some Boolean and one arithmetic.

The single group left at the end is driven out, and its lowest bit is the motor-direction command. By default the result is registered once before it leaves the block.

Top module: `layered_fe_array`

## Requirements
- R1: Routing element e (0..15) reads field cfg_bits[15e+14:15e]. Bit k (0..2) of its group equals din[s], where s is the 5-bit value at cfg_bits[15e+5k+4:15e+5k].
- R2: Function elements occupy consecutive 11-bit fields from bit 240 upward, layer by layer in the order layers 2, 3, 4, 5, and in ascending element order within a layer. Within a field, bits [3:0] select operand A, bits [7:4] select operand B and bits [10:8] hold the operation code.
- R3: An operand select is reduced modulo the group count of the previous layer, so 13 picks group 1 of a two-group layer and 7 picks group 1 of a six-group layer.
- R4: The operation codes are 0 pass A, 1 invert A, 2 add, 3 AND, 4 OR, 5 NAND, 6 NOR and 7 XOR, each applied bitwise on 3-bit operands except the add.
- R5: The add returns (A+B) mod 8, and its carry is lost.
- R6: Every configuration value yields a defined output equal to the layered evaluation of R1 to R5.
- R7: motor_right equals bit 0 of group_out, where 1 commands motion to the right.
- R8: group_out shows the result one clock after the inputs settle, and it reads 0 while rst_n is low.
- R9: The layers hold 16, 6, 4, 2 and 1 elements, and each layer reads only the layer directly before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| cfg_bits | input | 383 | Configuration word |
| din | input | 32 | Sensed state word |
| group_out | output | 3 | Final 3-bit group, registered |
| motor_right | output | 1 | Motor direction, 1 = right |

## Verification
Select wrapping and the carry-dropping add can occur in the same evaluation. This happens when a wrapped select feeds an add whose operands overflow 3 bits. The bench provokes it by pointing the last element's selects at 2 and 15 on a two-group layer with the add code and operands 7 and 5. The case passes only when the output is 4, which holds only if both rules apply together. The same pair of rules is also crossed at random in a sweep against an arithmetic model of the whole array.

// File: rtl/lfa_pkg.sv
package lfa_pkg;
  localparam int GRP_W = 3;
  localparam int OP_W  = 3;

  typedef logic [GRP_W-1:0] grp_t;

  typedef enum logic [OP_W-1:0] {
    OP_PASS = 3'd0,
    OP_INV  = 3'd1,
    OP_ADD  = 3'd2,
    OP_AND  = 3'd3,
    OP_OR   = 3'd4,
    OP_NAND = 3'd5,
    OP_NOR  = 3'd6,
    OP_XOR  = 3'd7
  } op_e;

  // Any select value lands on an existing group.
  function automatic int unsigned wrap_sel(input int unsigned s, input int unsigned n);
    return s % n;
  endfunction

  // Fixed eight-entry function cell; the add drops its carry.
  function automatic grp_t cell_eval(input op_e op, input grp_t a, input grp_t b);
    grp_t r;
    case (op)
      OP_PASS: r = a;
      OP_INV:  r = ~a;
      OP_ADD:  r = a + b;
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_NAND: r = ~(a & b);
      OP_NOR:  r = ~(a | b);
      default: r = a ^ b;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/lfa_route_layer.sv
module lfa_route_layer
  import lfa_pkg::*;
#(
  parameter int N_IN  = 32,
  parameter int N_EL  = 16,
  parameter int SEL_W = 5,
  localparam int FLD_W = GRP_W * SEL_W
) (
  input  logic [N_IN-1:0]        din_i,
  input  logic [N_EL*FLD_W-1:0]  cfg_i,
  output logic [N_EL*GRP_W-1:0]  grp_o
);
  for (genvar e = 0; e < N_EL; e++) begin : g_el
    for (genvar k = 0; k < GRP_W; k++) begin : g_bit
      logic [SEL_W-1:0] sel;
      assign sel = cfg_i[e*FLD_W + k*SEL_W +: SEL_W];
      assign grp_o[e*GRP_W + k] = din_i[wrap_sel(32'(sel), N_IN)];
    end
  end
endmodule

// File: rtl/lfa_combine_layer.sv
module lfa_combine_layer
  import lfa_pkg::*;
#(
  parameter int N_PREV = 16,
  parameter int N_EL   = 6,
  parameter int SEL_W  = 4,
  localparam int FLD_W = 2 * SEL_W + OP_W
) (
  input  logic [N_PREV*GRP_W-1:0] prev_i,
  input  logic [N_EL*FLD_W-1:0]   cfg_i,
  output logic [N_EL*GRP_W-1:0]   grp_o,
  output logic [N_EL*GRP_W-1:0]   opa_o,
  output logic [N_EL*GRP_W-1:0]   opb_o,
  output logic [N_EL*OP_W-1:0]    op_o
);
  for (genvar e = 0; e < N_EL; e++) begin : g_el
    logic [SEL_W-1:0] sa, sb;
    logic [OP_W-1:0]  opc;
    grp_t             a, b;
    assign sa  = cfg_i[e*FLD_W +: SEL_W];
    assign sb  = cfg_i[e*FLD_W + SEL_W +: SEL_W];
    assign opc = cfg_i[e*FLD_W + 2*SEL_W +: OP_W];
    assign a   = prev_i[wrap_sel(32'(sa), N_PREV)*GRP_W +: GRP_W];
    assign b   = prev_i[wrap_sel(32'(sb), N_PREV)*GRP_W +: GRP_W];
    assign grp_o[e*GRP_W +: GRP_W] = cell_eval(op_e'(opc), a, b);
    assign opa_o[e*GRP_W +: GRP_W] = a;
    assign opb_o[e*GRP_W +: GRP_W] = b;
    assign op_o[e*OP_W +: OP_W]    = opc;
  end
endmodule

// File: rtl/layered_fe_array.sv
module layered_fe_array
  import lfa_pkg::*;
#(
  parameter int N_IN    = 32,
  parameter int L1_N    = 16,
  parameter int L2_N    = 6,
  parameter int L3_N    = 4,
  parameter int L4_N    = 2,
  parameter bit REG_OUT = 1'b1,
  localparam int SEL_IN_W = $clog2(N_IN),
  localparam int SEL_G_W  = $clog2(L1_N),
  localparam int F1_W     = GRP_W * SEL_IN_W,
  localparam int FC_W     = 2 * SEL_G_W + OP_W,
  localparam int OFF2     = L1_N * F1_W,
  localparam int OFF3     = OFF2 + L2_N * FC_W,
  localparam int OFF4     = OFF3 + L3_N * FC_W,
  localparam int OFF5     = OFF4 + L4_N * FC_W,
  localparam int CFG_W    = OFF5 + FC_W,
  localparam int N_CELL   = L2_N + L3_N + L4_N + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_bits,
  input  logic [N_IN-1:0]  din,
  output logic [GRP_W-1:0] group_out,
  output logic             motor_right
);
  logic [L1_N*GRP_W-1:0] grp1;
  logic [L2_N*GRP_W-1:0] grp2, a2, b2;
  logic [L3_N*GRP_W-1:0] grp3, a3, b3;
  logic [L4_N*GRP_W-1:0] grp4, a4, b4;
  logic [GRP_W-1:0]      grp5, a5, b5;
  logic [L2_N*OP_W-1:0]  op2;
  logic [L3_N*OP_W-1:0]  op3;
  logic [L4_N*OP_W-1:0]  op4;
  logic [OP_W-1:0]       op5;

  // Named taps for the checker: every function cell's operands, code, result.
  logic [N_CELL*GRP_W-1:0] cell_a, cell_b, cell_res;
  logic [N_CELL*OP_W-1:0]  cell_op;
  grp_t                    fin_grp;

  lfa_route_layer #(.N_IN(N_IN), .N_EL(L1_N), .SEL_W(SEL_IN_W)) u_l1 (
    .din_i(din), .cfg_i(cfg_bits[OFF2-1:0]), .grp_o(grp1));

  lfa_combine_layer #(.N_PREV(L1_N), .N_EL(L2_N), .SEL_W(SEL_G_W)) u_l2 (
    .prev_i(grp1), .cfg_i(cfg_bits[OFF3-1:OFF2]), .grp_o(grp2),
    .opa_o(a2), .opb_o(b2), .op_o(op2));

  lfa_combine_layer #(.N_PREV(L2_N), .N_EL(L3_N), .SEL_W(SEL_G_W)) u_l3 (
    .prev_i(grp2), .cfg_i(cfg_bits[OFF4-1:OFF3]), .grp_o(grp3),
    .opa_o(a3), .opb_o(b3), .op_o(op3));

  lfa_combine_layer #(.N_PREV(L3_N), .N_EL(L4_N), .SEL_W(SEL_G_W)) u_l4 (
    .prev_i(grp3), .cfg_i(cfg_bits[OFF5-1:OFF4]), .grp_o(grp4),
    .opa_o(a4), .opb_o(b4), .op_o(op4));

  lfa_combine_layer #(.N_PREV(L4_N), .N_EL(1), .SEL_W(SEL_G_W)) u_l5 (
    .prev_i(grp4), .cfg_i(cfg_bits[CFG_W-1:OFF5]), .grp_o(grp5),
    .opa_o(a5), .opb_o(b5), .op_o(op5));

  assign cell_a   = {a5, a4, a3, a2};
  assign cell_b   = {b5, b4, b3, b2};
  assign cell_res = {grp5, grp4, grp3, grp2};
  assign cell_op  = {op5, op4, op3, op2};
  assign fin_grp  = grp5;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) group_out <= '0;
      else        group_out <= fin_grp;
    end
  end else begin : g_comb
    assign group_out = fin_grp;
  end

  assign motor_right = group_out[0];
endmodule

// File: rtl/lfa_checker.sv
module lfa_checker
  import lfa_pkg::*;
#(
  parameter int N_CELL  = 13,
  parameter bit REG_OUT = 1'b1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_CELL*GRP_W-1:0] cell_a,
  input logic [N_CELL*GRP_W-1:0] cell_b,
  input logic [N_CELL*GRP_W-1:0] cell_res,
  input logic [N_CELL*OP_W-1:0]  cell_op,
  input logic [GRP_W-1:0]        fin_grp,
  input logic [GRP_W-1:0]        group_out
);
  for (genvar c = 0; c < N_CELL; c++) begin : g_cell
    grp_t a, b, r;
    logic [OP_W-1:0] op;
    assign a  = cell_a[c*GRP_W +: GRP_W];
    assign b  = cell_b[c*GRP_W +: GRP_W];
    assign r  = cell_res[c*GRP_W +: GRP_W];
    assign op = cell_op[c*OP_W +: OP_W];

    // R4
    and_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_AND) |-> ((r & ~a) == '0 && (r & ~b) == '0));
    // R4
    or_superset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_OR) |-> ((r & a) == a && (r & b) == b));
    // R4
    inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_INV) |-> ((r ^ a) == 3'b111));
    // R5
    add_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_ADD) |-> (grp_t'(r - a) == b));
  end

  if (REG_OUT) begin : g_lat
    // R8
    reg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (group_out == $past(fin_grp)));
  end
endmodule

bind layered_fe_array lfa_checker #(.N_CELL(N_CELL), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cell_a(cell_a), .cell_b(cell_b),
  .cell_res(cell_res), .cell_op(cell_op), .fin_grp(fin_grp),
  .group_out(group_out));

// File: tb/layered_fe_array_tb.sv
module layered_fe_array_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [382:0] cfg_r = '0;
  logic [31:0]  din_r = '0;
  logic [2:0]   group_out;
  logic         motor_right;
  int           n_chk = 0;
  int           n_bad = 0;
  int           cycles = 0;
  bit           done = 1'b0;

  always #10 clk = ~clk;

  layered_fe_array u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_bits(cfg_r), .din(din_r),
    .group_out(group_out), .motor_right(motor_right));

  function automatic int cnt_of(input int l);
    case (l)
      1: return 16;
      2: return 6;
      3: return 4;
      4: return 2;
      default: return 1;
    endcase
  endfunction

  function automatic int op_ref(input int op, input int a, input int b);
    case (op)
      0: return a;
      1: return 7 - a;
      2: return (a + b) % 8;
      3: return a & b;
      4: return a | b;
      5: return 7 - (a & b);
      6: return 7 - (a | b);
      default: return a ^ b;
    endcase
  endfunction

  function automatic logic [2:0] ref_eval(input logic [382:0] c, input logic [31:0] d);
    int pv[16];
    int nx[16];
    int off;
    for (int e = 0; e < 16; e++) begin
      pv[e] = 0;
      for (int k = 0; k < 3; k++)
        pv[e] += int'(d[c[e*15 + k*5 +: 5]]) << k;
    end
    off = 240;
    for (int l = 2; l <= 5; l++) begin
      for (int e = 0; e < cnt_of(l); e++) begin
        nx[e] = op_ref(int'(c[off+8 +: 3]),
                       pv[int'(c[off +: 4]) % cnt_of(l-1)],
                       pv[int'(c[off+4 +: 4]) % cnt_of(l-1)]);
        off += 11;
      end
      for (int e = 0; e < cnt_of(l); e++) pv[e] = nx[e];
    end
    return 3'(pv[0]);
  endfunction

  function automatic int cell_base(input int l);
    int o = 240;
    for (int j = 2; j < l; j++) o += 11 * cnt_of(j);
    return o;
  endfunction

  task automatic set_l1(input int e, input int s0, input int s1, input int s2);
    cfg_r[e*15 +: 5]      = 5'(s0);
    cfg_r[e*15 + 5 +: 5]  = 5'(s1);
    cfg_r[e*15 + 10 +: 5] = 5'(s2);
  endtask

  task automatic set_cell(input int l, input int e, input int sa, input int sb, input int op);
    int o = cell_base(l) + 11 * e;
    cfg_r[o +: 4]     = 4'(sa);
    cfg_r[o + 4 +: 4] = 4'(sb);
    cfg_r[o + 8 +: 3] = 3'(op);
  endtask

  // Groups 0 and 1 of layer 1 carry din[2:0] and din[5:3] straight to layer 5.
  task automatic base_cfg(input int op);
    cfg_r = '0;
    set_l1(0, 0, 1, 2);
    set_l1(1, 3, 4, 5);
    for (int l = 2; l <= 4; l++) begin
      set_cell(l, 0, 0, 0, 0);
      set_cell(l, 1, 1, 0, 0);
    end
    set_cell(5, 0, 0, 1, op);
  endtask

  task automatic check(input string req, input logic [2:0] exp);
    n_chk++;
    if (group_out !== exp) begin
      n_bad++;
      $display("FAIL %s group_out actual=%0d expected=%0d", req, group_out, exp);
    end else if (motor_right !== exp[0]) begin
      n_bad++;
      $display("FAIL R7 motor_right actual=%0b expected=%0b", motor_right, exp[0]);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  initial begin
    base_cfg(0);
    din_r = 32'h0000_0007;
    repeat (3) @(negedge clk);
    // R8: output held at 0 during reset despite a nonzero result
    check("R8 reset", 3'd0);
    rst_n = 1'b1;
    settle();
    check("R8 after reset", 3'd7);

    // R4 R5 R7: every code on every operand pair
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++) begin
          @(negedge clk);
          base_cfg(op);
          din_r = 32'(a) | (32'(b) << 3);
          settle();
          check(op == 2 ? "R5 add" : "R4 op table", 3'(op_ref(op, a, b)));
        end

    // R1: scattered input bits routed into a group
    base_cfg(0);
    set_l1(0, 31, 17, 8);
    din_r = 32'h8000_0100;
    settle();
    check("R1 route", 3'b101);
    din_r = 32'h0002_0000;
    settle();
    check("R1 route", 3'b010);

    // R2: B select and code field positions
    base_cfg(0);
    set_cell(5, 0, 0, 1, 7);
    din_r = 32'(3) | (32'(6) << 3);
    settle();
    check("R2 fields", 3'd5);

    // R3: wrap on two-group layer (13 -> 1)
    base_cfg(0);
    set_cell(5, 0, 13, 0, 0);
    din_r = 32'(2) | (32'(6) << 3);
    settle();
    check("R3 wrap two", 3'd6);
    // R3: wrap on six-group layer (7 -> 1)
    base_cfg(0);
    set_cell(3, 0, 7, 0, 0);
    din_r = 32'(1) | (32'(4) << 3);
    settle();
    check("R3 wrap six", 3'd4);
    // R3 R5: wrapped selects feeding a carrying add
    base_cfg(0);
    set_cell(5, 0, 2, 15, 2);
    din_r = 32'(7) | (32'(5) << 3);
    settle();
    check("R3 R5 wrap plus carry", 3'd4);

    // R8: output keeps old value until the next edge
    base_cfg(0);
    din_r = 32'd1;
    settle();
    check("R8 settled", 3'd1);
    @(negedge clk);
    din_r = 32'd6;
    #2;
    check("R8 latency hold", 3'd1);
    @(negedge clk);
    check("R8 latency update", 3'd6);

    // R8: asynchronous clear mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    check("R8 async clear", 3'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 recover", 3'd6);

    // R6 R9: random configurations against the layered model
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      for (int w = 0; w < 12; w++) cfg_r[w*32 +: 32] = $urandom;
      cfg_r[382:352] = 31'($urandom);
      din_r = $urandom;
      settle();
      check("R6 R9 random", ref_eval(cfg_r, din_r));
    end

    finish_run();
  end
endmodule